// File: doc/BRIEF.md
# Adaptive exponential neuron integrator

This block is a fixed-point digital neuron. On every clock edge where the core-enable input is high, it advances two state variables by one forward-Euler step of the adaptive exponential integrate-and-fire equations. The first variable is the membrane potential V. The second is the adaptation current w. The exponential spike-initiation term is approximated with shifts. Division by the capacitance C and by the adaptation time constant τw is replaced by right shifts. The leak conductance gL and the rest potential EL are fixed internal constants.

Eight 8-bit parameters drive the block. They come from a register bank, elsewhere in the chip, that holds committed values. When a step carries V to or beyond the threshold, three things happen at the same edge:

- the block emits a one-cycle spike;
- V is reloaded with the reset potential;
- w is raised by the spike-triggered increment.

A debug output shows the upper six bits of either V or w.

Both states are 12-bit signed Q4.8 values. Intermediate sums run at 24 bits, and both states saturate at the Q4.8 limits instead of wrapping.

Top module: `adex_neuron`

## Requirements
- R1: Reset is synchronous and active-low. An edge with rst_n low loads V with EL = -1120 (-70·16, that is -4.375) and w with 0, and clears spike_o. It also loads dbg_o with the view of those values that dbg_sel selects (V gives 6'h2E, w gives 6'h00).
- R2: V and w are 12-bit signed Q4.8 values. Parameter scaling:
  - The threshold, reset-potential and bias codes c are offset by 128, so each means (c-128)·16 LSBs.
  - The ΔT code means ΔT·16 LSBs, and the b code means b·16 LSBs.
  - The a code is a gain of a/16.
  - gL is fixed at 1/8.
  - lg(x) is the index of the highest set bit of x, or 0 when x is 0.
- R3: While core_en is low, V and w keep their values and spike_o stays low.
- R4: In an enabled step without a spike, V' = sat(V + (S >>> lg(C))), where S = E - ((V-EL) >>> 3) - w + I. Here I is the scaled bias and >>> is an arithmetic (flooring) shift.
- R5: In an enabled step without a spike, w' = sat(w + ((((a·(V-EL)) >>> 4) - w) >>> lg(τw))).
- R6: The exponential term E is defined as follows:
  - E is 0 when ΔT = 0.
  - Otherwise let d = (V-VT) >>> (lg(ΔT)+4) and base = 2·ΔT.
  - For d < 0, E = base >> min(-d, 15).
  - For d ≥ 0, E = min(base << d, 1024), and E = 1024 whenever d ≥ 4.
- R7: A spike occurs when the V' from R4 is at or above the scaled threshold VT. spike_o is then high for the single cycle that follows that edge. It stays high in later cycles only if each following step spikes as well.
- R8: On a spike edge, V is loaded with sat of the scaled reset potential, and w with sat(w + 16·b). The Euler results for that step are discarded.
- R9: V and w saturate at +2047 and -2048 LSBs instead of wrapping.
- R10: dbg_o is registered. After each edge it carries bits [11:6] of the state just written: V when dbg_sel was 0 at that edge, w when it was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_en | input | 1 | Advance the state on this edge |
| dbg_sel | input | 1 | Debug view select: 0 shows V, 1 shows w |
| prm_dt | input | 8 | Spike sharpness ΔT, unsigned |
| prm_tauw | input | 8 | Adaptation time constant, used as shift lg(τw) |
| prm_a | input | 8 | Subthreshold adaptation gain, a/16 |
| prm_b | input | 8 | Spike-triggered adaptation increment, unsigned |
| prm_vreset | input | 8 | Reset potential, offset-128 code |
| prm_vthr | input | 8 | Threshold potential, offset-128 code |
| prm_ibias | input | 8 | Bias current, offset-128 code |
| prm_cap | input | 8 | Capacitance, used as shift lg(C) |
| spike_o | output | 1 | One-cycle spike pulse |
| dbg_o | output | 6 | Top six bits of V or w |

## Verification
The integrator is run with six parameter sets, and each set separates a different part of the step:

- an adapting set, where w grows with every spike;
- a reset-near-threshold set with strong subthreshold gain, where adaptation comes only from a;
- a set with no adaptation at all;
- a strong-bias set;
- a set with a wide ΔT and a short τw, where the exponential term is large;
- a set with ΔT, C and τw all zero, which turns off the exponential and the shifts.

For every set, the debug view alternates between V and w every 16 cycles, and each cycle is compared with a model written from the requirements. As a result, an error in the V path and an error in the w path show up separately.

Directed cases drive each saturation rail that can be reached, check that the spike reload and the w bump appear on the first spike edge, and check that the state holds while core_en is low.

// File: rtl/adex_pkg.sv
`timescale 1ns/1ps
package adex_pkg;
  localparam int STATE_W = 12;
  localparam int PARAM_W = 8;
  localparam int CALC_W  = 24;
  localparam int DBG_W   = 6;

  typedef logic signed [STATE_W-1:0] state_t;
  typedef logic signed [CALC_W-1:0]  calc_t;

  localparam calc_t ST_MAX = calc_t'((1 << (STATE_W-1)) - 1);
  localparam calc_t ST_MIN = -ST_MAX - calc_t'(1);
  localparam calc_t CODE_OFFSET = calc_t'(1 << (PARAM_W-1));

  // index of the highest set bit, zero for an all-zero input
  function automatic int lead_one(input logic [PARAM_W-1:0] x);
    int r;
    r = 0;
    for (int i = 0; i < PARAM_W; i++) begin
      if (x[i]) r = i;
    end
    return r;
  endfunction

  function automatic state_t sat_state(input calc_t x);
    state_t r;
    if (x > ST_MAX)      r = ST_MAX[STATE_W-1:0];
    else if (x < ST_MIN) r = ST_MIN[STATE_W-1:0];
    else                 r = x[STATE_W-1:0];
    return r;
  endfunction

  function automatic calc_t zext(input logic [PARAM_W-1:0] c);
    return $signed({{(CALC_W-PARAM_W){1'b0}}, c});
  endfunction

  // offset-coded signed parameter scaled into state LSBs
  function automatic calc_t scode(input logic [PARAM_W-1:0] c, input int sh);
    return (zext(c) - CODE_OFFSET) <<< sh;
  endfunction
endpackage

// File: rtl/adex_exp_term.sv
`timescale 1ns/1ps
module adex_exp_term
  import adex_pkg::*;
#(
  parameter int PAR_SHIFT = 4,
  parameter int EXP_NMAX  = 4,
  parameter int EXP_MAX   = 1024
) (
  input  state_t             v,
  input  calc_t              vt_q,
  input  logic [PARAM_W-1:0] dt,
  output calc_t              e
);
  localparam calc_t E_CAP = calc_t'(EXP_MAX);
  localparam calc_t N_CAP = calc_t'(EXP_NMAX);
  localparam calc_t RSH_CAP = calc_t'(15);

  calc_t x, d, nd, base, up;
  logic [3:0] rsh;

  always_comb begin
    x    = calc_t'(v) - vt_q;
    d    = x >>> (lead_one(dt) + PAR_SHIFT);
    base = zext(dt) <<< 1;
    nd   = -d;
    rsh  = (nd > RSH_CAP) ? 4'd15 : nd[3:0];
    up   = base <<< d;
    if (dt == '0) begin
      e = '0;
    end else if (d[CALC_W-1]) begin
      e = base >>> rsh;
    end else if (d >= N_CAP) begin
      e = E_CAP;
    end else begin
      e = (up > E_CAP) ? E_CAP : up;
    end
  end
endmodule

// File: rtl/adex_euler_step.sv
`timescale 1ns/1ps
module adex_euler_step
  import adex_pkg::*;
#(
  parameter int    GL_SHIFT  = 3,
  parameter int    A_SHIFT   = 4,
  parameter int    PAR_SHIFT = 4,
  parameter calc_t EL_Q      = -calc_t'(1120)
) (
  input  state_t             v,
  input  state_t             w,
  input  calc_t              e,
  input  calc_t              vt_q,
  input  calc_t              vr_q,
  input  calc_t              ib_q,
  input  logic [PARAM_W-1:0] a,
  input  logic [PARAM_W-1:0] b,
  input  logic [PARAM_W-1:0] cap,
  input  logic [PARAM_W-1:0] tauw,
  output state_t             v_next,
  output state_t             w_next,
  output logic               fire
);
  calc_t dvl, drive, aterm, dw;
  state_t v_eul, w_eul;

  always_comb begin
    dvl   = calc_t'(v) - EL_Q;
    drive = e - (dvl >>> GL_SHIFT) - calc_t'(w) + ib_q;
    v_eul = sat_state(calc_t'(v) + (drive >>> lead_one(cap)));
    aterm = (zext(a) * dvl) >>> A_SHIFT;
    dw    = (aterm - calc_t'(w)) >>> lead_one(tauw);
    w_eul = sat_state(calc_t'(w) + dw);
    fire  = (calc_t'(v_eul) >= vt_q);
    if (fire) begin
      v_next = sat_state(vr_q);
      w_next = sat_state(calc_t'(w) + (zext(b) <<< PAR_SHIFT));
    end else begin
      v_next = v_eul;
      w_next = w_eul;
    end
  end
endmodule

// File: rtl/adex_state_reg.sv
`timescale 1ns/1ps
module adex_state_reg
  import adex_pkg::*;
#(
  parameter state_t EL_S = -state_t'(1120)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_en,
  input  logic             dbg_sel,
  input  state_t           v_next,
  input  state_t           w_next,
  input  logic             fire,
  output state_t           v_q,
  output state_t           w_q,
  output logic             spike_q,
  output logic [DBG_W-1:0] dbg_q
);
  state_t v_d, w_d;
  logic   sp_d;

  always_comb begin
    if (!rst_n) begin
      v_d  = EL_S;
      w_d  = '0;
      sp_d = 1'b0;
    end else if (core_en) begin
      v_d  = v_next;
      w_d  = w_next;
      sp_d = fire;
    end else begin
      v_d  = v_q;
      w_d  = w_q;
      sp_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    v_q     <= v_d;
    w_q     <= w_d;
    spike_q <= sp_d;
    dbg_q   <= dbg_sel ? w_d[STATE_W-1 -: DBG_W] : v_d[STATE_W-1 -: DBG_W];
  end
endmodule

// File: rtl/adex_neuron.sv
`timescale 1ns/1ps
module adex_neuron
  import adex_pkg::*;
#(
  parameter int GL_SHIFT  = 3,
  parameter int A_SHIFT   = 4,
  parameter int PAR_SHIFT = 4,
  parameter int EL_CODE   = -70,
  parameter int EXP_NMAX  = 4,
  parameter int EXP_MAX   = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               core_en,
  input  logic               dbg_sel,
  input  logic [PARAM_W-1:0] prm_dt,
  input  logic [PARAM_W-1:0] prm_tauw,
  input  logic [PARAM_W-1:0] prm_a,
  input  logic [PARAM_W-1:0] prm_b,
  input  logic [PARAM_W-1:0] prm_vreset,
  input  logic [PARAM_W-1:0] prm_vthr,
  input  logic [PARAM_W-1:0] prm_ibias,
  input  logic [PARAM_W-1:0] prm_cap,
  output logic               spike_o,
  output logic [DBG_W-1:0]   dbg_o
);
  localparam calc_t  EL_Q = calc_t'(EL_CODE) <<< PAR_SHIFT;
  localparam state_t EL_S = EL_Q[STATE_W-1:0];

  calc_t  vt_q, vr_q, ib_q, e;
  state_t v_q, w_q, v_next, w_next;
  logic   fire;

  assign vt_q = scode(prm_vthr,   PAR_SHIFT);
  assign vr_q = scode(prm_vreset, PAR_SHIFT);
  assign ib_q = scode(prm_ibias,  PAR_SHIFT);

  adex_exp_term #(
    .PAR_SHIFT(PAR_SHIFT), .EXP_NMAX(EXP_NMAX), .EXP_MAX(EXP_MAX)
  ) u_exp (
    .v(v_q), .vt_q(vt_q), .dt(prm_dt), .e(e)
  );

  adex_euler_step #(
    .GL_SHIFT(GL_SHIFT), .A_SHIFT(A_SHIFT), .PAR_SHIFT(PAR_SHIFT), .EL_Q(EL_Q)
  ) u_step (
    .v(v_q), .w(w_q), .e(e), .vt_q(vt_q), .vr_q(vr_q), .ib_q(ib_q),
    .a(prm_a), .b(prm_b), .cap(prm_cap), .tauw(prm_tauw),
    .v_next(v_next), .w_next(w_next), .fire(fire)
  );

  adex_state_reg #(
    .EL_S(EL_S)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .dbg_sel(dbg_sel),
    .v_next(v_next), .w_next(w_next), .fire(fire),
    .v_q(v_q), .w_q(w_q), .spike_q(spike_o), .dbg_q(dbg_o)
  );
endmodule

// File: rtl/adex_neuron_chk.sv
`timescale 1ns/1ps
module adex_neuron_chk
  import adex_pkg::*;
#(
  parameter int PAR_SHIFT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               core_en,
  input logic               dbg_sel,
  input logic [PARAM_W-1:0] prm_vreset,
  input logic [PARAM_W-1:0] prm_b,
  input state_t             v_q,
  input state_t             w_q,
  input logic               spike_o,
  input logic [DBG_W-1:0]   dbg_o
);
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> ($stable(v_q) && $stable(w_q))); // R3
  AST_NO_SPIKE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> !spike_o); // R7
  AST_SPIKE_SETS_VRESET: assert property (@(posedge clk) disable iff (!rst_n)
    spike_o |-> (v_q == sat_state(scode($past(prm_vreset), PAR_SHIFT)))); // R8
  AST_SPIKE_BUMPS_W: assert property (@(posedge clk) disable iff (!rst_n)
    spike_o |-> (w_q == sat_state(calc_t'($past(w_q)) + (zext($past(prm_b)) <<< PAR_SHIFT)))); // R8
  AST_DBG_VIEW: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_o == ($past(dbg_sel) ? w_q[STATE_W-1 -: DBG_W] : v_q[STATE_W-1 -: DBG_W])); // R10
endmodule

bind adex_neuron adex_neuron_chk u_chk (
  .clk(clk), .rst_n(rst_n), .core_en(core_en), .dbg_sel(dbg_sel),
  .prm_vreset(prm_vreset), .prm_b(prm_b), .v_q(v_q), .w_q(w_q),
  .spike_o(spike_o), .dbg_o(dbg_o)
);

// File: tb/tb_adex_neuron.sv
`timescale 1ns/1ps
module tb_adex_neuron;
  typedef struct packed {
    logic [7:0] dt, tw, a, b, vr, vt, ib, c;
    logic [15:0] n;
  } row_t;

  // dt, tauw, a, b, vreset, vthr, ibias, cap, cycles
  localparam row_t ROWS [6] = '{
    '{8'd2,  8'd64, 8'd2, 8'd40, 8'd63, 8'd78, 8'd178, 8'd200, 16'd600},
    '{8'd2,  8'd64, 8'd4, 8'd0,  8'd78, 8'd88, 8'd153, 8'd200, 16'd600},
    '{8'd2,  8'd64, 8'd0, 8'd0,  8'd63, 8'd78, 8'd208, 8'd200, 16'd600},
    '{8'd2,  8'd64, 8'd2, 8'd40, 8'd63, 8'd78, 8'd200, 8'd200, 16'd600},
    '{8'd16, 8'd8,  8'd6, 8'd20, 8'd70, 8'd90, 8'd160, 8'd64,  16'd600},
    '{8'd0,  8'd0,  8'd1, 8'd3,  8'd70, 8'd100,8'd140, 8'd0,   16'd300}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, core_en = 1'b0, dbg_sel = 1'b0;
  logic [7:0] p_dt = 0, p_tw = 0, p_a = 0, p_b = 0, p_vr = 0, p_vt = 0, p_ib = 0, p_c = 0;
  logic spike_o;
  logic [5:0] dbg_o;

  int n_tests = 0, n_fail = 0;
  int mv = -1120, mw = 0, msp = 0, mdbg = 0;
  int mism = 0, dspk = 0, mspk = 0;

  always #4 clk = ~clk;

  adex_neuron dut (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .dbg_sel(dbg_sel),
    .prm_dt(p_dt), .prm_tauw(p_tw), .prm_a(p_a), .prm_b(p_b),
    .prm_vreset(p_vr), .prm_vthr(p_vt), .prm_ibias(p_ib), .prm_cap(p_c),
    .spike_o(spike_o), .dbg_o(dbg_o)
  );

  function automatic int lg8(input logic [7:0] x);
    int r = 0;
    for (int i = 0; i < 8; i++) if (x[i]) r = i;
    return r;
  endfunction

  function automatic int sat12(input int x);
    if (x > 2047) return 2047;
    if (x < -2048) return -2048;
    return x;
  endfunction

  function automatic int top6(input int x);
    return (x & 32'hFFF) >> 6;
  endfunction

  // reference step written from R1..R10
  task automatic model_step();
    int vt, vr, ib, x, d, base, e, dvl, s, vs, ws, sh;
    if (!rst_n) begin
      mv = -1120; mw = 0; msp = 0;
    end else if (!core_en) begin
      msp = 0;
    end else begin
      vt = (int'(p_vt) - 128) * 16;
      vr = (int'(p_vr) - 128) * 16;
      ib = (int'(p_ib) - 128) * 16;
      x = mv - vt;
      e = 0;
      if (p_dt != 0) begin
        d = x >>> (lg8(p_dt) + 4);
        base = int'(p_dt) * 2;
        if (d < 0) begin
          sh = (-d > 15) ? 15 : -d;
          e = base >> sh;
        end else if (d >= 4) e = 1024;
        else e = ((base << d) > 1024) ? 1024 : (base << d);
      end
      dvl = mv - (-1120);
      s = e - (dvl >>> 3) - mw + ib;
      vs = sat12(mv + (s >>> lg8(p_c)));
      ws = sat12(mw + ((((int'(p_a) * dvl) >>> 4) - mw) >>> lg8(p_tw)));
      if (vs >= vt) begin
        mv = sat12(vr); mw = sat12(mw + 16 * int'(p_b)); msp = 1;
      end else begin
        mv = vs; mw = ws; msp = 0;
      end
    end
    mdbg = dbg_sel ? top6(mw) : top6(mv);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    if (spike_o !== msp[0] || dbg_o !== mdbg[5:0]) mism++;
    if (spike_o) dspk++;
    if (msp != 0) mspk++;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input row_t r);
    p_dt = r.dt; p_tw = r.tw; p_a = r.a; p_b = r.b;
    p_vr = r.vr; p_vt = r.vt; p_ib = r.ib; p_c = r.c;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; core_en = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int a0, b0;
    @(negedge clk);
    // R1 reset state
    dbg_sel = 1'b0;
    do_reset();
    chk(spike_o == 1'b0, "R1 spike after reset", int'(spike_o), 0);
    chk(dbg_o == 6'h2E, "R1 V view after reset", int'(dbg_o), 46);
    dbg_sel = 1'b1; tick();
    chk(dbg_o == 6'h00, "R1 R10 w view after reset", int'(dbg_o), 0);

    // vector table: R2 R4 R5 R6 R7 R8 R10 against the model
    for (int r = 0; r < 6; r++) begin
      load(ROWS[r]);
      dbg_sel = 1'b0;
      do_reset();
      mism = 0; dspk = 0; mspk = 0;
      core_en = 1'b1;
      for (int i = 0; i < int'(ROWS[r].n); i++) begin
        dbg_sel = i[4];
        tick();
      end
      core_en = 1'b0;
      chk(mism == 0, $sformatf("R4 R5 R6 R10 row %0d cycle mismatches", r), mism, 0);
      chk(dspk == mspk, $sformatf("R7 R2 row %0d spike count", r), dspk, mspk);
    end

    // R3 hold with core_en low
    load(ROWS[3]);
    dbg_sel = 1'b0; do_reset();
    core_en = 1'b1;
    for (int i = 0; i < 10; i++) tick();
    core_en = 1'b0; dbg_sel = 1'b0; tick(); a0 = int'(dbg_o);
    dbg_sel = 1'b1; tick(); b0 = int'(dbg_o);
    dspk = 0;
    dbg_sel = 1'b0;
    for (int i = 0; i < 8; i++) tick();
    chk(int'(dbg_o) == a0, "R3 V held", int'(dbg_o), a0);
    dbg_sel = 1'b1; tick();
    chk(int'(dbg_o) == b0, "R3 w held", int'(dbg_o), b0);
    chk(dspk == 0, "R3 no spike while idle", dspk, 0);

    // R7 R8 first step spike: V -> -448, w -> 80
    load('{8'd0, 8'd1, 8'd0, 8'd5, 8'd100, 8'd120, 8'd255, 8'd1, 16'd0});
    dbg_sel = 1'b0; do_reset();
    core_en = 1'b1; tick();
    chk(spike_o == 1'b1, "R7 spike on crossing", int'(spike_o), 1);
    chk(dbg_o == 6'h39, "R8 V reloaded", int'(dbg_o), 57);
    core_en = 1'b0; dbg_sel = 1'b1; tick();
    chk(spike_o == 1'b0, "R7 single cycle pulse", int'(spike_o), 0);
    chk(dbg_o == 6'h01, "R8 w bumped by 16b", int'(dbg_o), 1);

    // R9 w positive rail via bump
    load('{8'd0, 8'd128, 8'd0, 8'd255, 8'd255, 8'd0, 8'd128, 8'd200, 16'd0});
    dbg_sel = 1'b1; do_reset();
    core_en = 1'b1; tick();
    chk(dbg_o == 6'h1F, "R9 w saturates high", int'(dbg_o), 31);

    // R9 negative rails for V and w
    load('{8'd0, 8'd1, 8'd255, 8'd0, 8'd128, 8'd255, 8'd0, 8'd1, 16'd0});
    dbg_sel = 1'b0; do_reset();
    core_en = 1'b1; tick();
    chk(dbg_o == 6'h20, "R9 V saturates low", int'(dbg_o), 32);
    chk(spike_o == 1'b0, "R7 no spike below threshold", int'(spike_o), 0);
    dbg_sel = 1'b1; tick();
    chk(dbg_o == 6'h20, "R9 w saturates low", int'(dbg_o), 32);
    core_en = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule